// File: doc/BRIEF.md
# Muxed Cascaded Clock Divider

This block produces a subsystem clock by picking one of four source clocks and dividing it down. Each source is presented as a one-cycle tick on a common system clock, and the divided output is likewise a one-cycle tick. A single 32-bit control word holds three fields: a source selector, a post-divide code shared by every source, and a pre-divide code that is used only when the last source is selected. When that source is chosen, the pre-divider is cascaded ahead of the post-divider, so the overall ratio is the product of the two.

Software loads the control word through a simple write/read port. A full write replaces the whole word. A divider-only write updates just the two divide fields and leaves the selector and every other bit alone, as a read-modify-write would. New settings never cut an output period short. The running counters finish their current period on the old settings and pick up the new ones at the period boundary, so a write cannot produce a runt tick.

Top module: `muxclk_cascade_div`

## Requirements
- R1: After reset the control word reads as 0 (source 0, both ratios 1), and every tick on source 0 produces an output tick.
- R2: Bits 17:16 select the source (0 to 3). Ticks on the sources that are not selected have no effect on the output.
- R3: Bits 5:4 hold the post-divide code c, with ratio c+1 (1 to 4). The output ticks once for every c+1 ticks that reach the post-divider.
- R4: Bits 12:8 hold the pre-divide code p, with ratio p+1 (1 to 32). It takes effect only when the selector is 3.
- R5: With the selector at 0, 1 or 2, the pre-divide field has no effect, and the ratio is the post ratio alone.
- R6: With the selector at 3, the output ticks once every (p+1)*(c+1) source-3 ticks.
- R7: A divider-only write (`div_wr`) changes bits 12:8 and 5:4 and leaves all other bits of the word unchanged. If a full write (`cfg_wr`) happens in the same cycle, the full write wins.
- R8: Reads return the last value written, with every bit outside 17:16, 12:8 and 5:4 reading as 0.
- R9: A write takes effect only at the end of the output period in progress. The remaining ticks of that period are counted on the old source and ratios.
- R10: An output tick is a single cycle. It appears in the clock cycle after the source tick that completes the period, so a total ratio of 1 passes each tick through with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all ticks are sampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | One-cycle tick for each source clock |
| cfg_wr | input | 1 | Full control-word write strobe |
| div_wr | input | 1 | Divider-fields-only write strobe |
| cfg_wdata | input | 32 | Write data for either strobe |
| cfg_rdata | output | 32 | Current control word, unused bits zero |
| out_tick | output | 1 | Divided output tick |

## Verification
The assertions assume that each source tick lasts exactly one system cycle. They also assume that the write strobes and data are stable around the clock edge, so that a tick or a write is seen exactly once. The bench drives every input at the falling edge and holds each tick for one cycle. It starts a new configuration only after it has counted out the full old period, and it checks the mid-period case on purpose. This keeps the counters' range and hold properties within what they assume.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

   localparam int unsigned CFG_W        = 32;
   localparam int unsigned SRC_N_DEF    = 4;
   localparam int unsigned SEL_LSB_DEF  = 16;
   localparam int unsigned PRE_LSB_DEF  = 8;
   localparam int unsigned PRE_W_DEF    = 5;
   localparam int unsigned POST_LSB_DEF = 4;
   localparam int unsigned POST_W_DEF   = 2;

   // Build a mask of w ones starting at bit lsb.
   function automatic logic [CFG_W-1:0] field_mask(input int unsigned lsb,
                                                   input int unsigned w);
      logic [CFG_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < CFG_W; i++) begin
         if (i >= lsb && i < lsb + w) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/cdiv_cfg_reg.sv
module cdiv_cfg_reg
   import cdiv_pkg::*;
#(
   parameter int unsigned SEL_LSB  = SEL_LSB_DEF,
   parameter int unsigned SEL_W    = 2,
   parameter int unsigned PRE_LSB  = PRE_LSB_DEF,
   parameter int unsigned PRE_W    = PRE_W_DEF,
   parameter int unsigned POST_LSB = POST_LSB_DEF,
   parameter int unsigned POST_W   = POST_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_all,
   input  logic             wr_div,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] word_q,
   output logic [SEL_W-1:0] sel_o,
   output logic [PRE_W-1:0] pre_o,
   output logic [POST_W-1:0] post_o
);

   localparam logic [CFG_W-1:0] SEL_M  = field_mask(SEL_LSB, SEL_W);
   localparam logic [CFG_W-1:0] PRE_M  = field_mask(PRE_LSB, PRE_W);
   localparam logic [CFG_W-1:0] POST_M = field_mask(POST_LSB, POST_W);
   localparam logic [CFG_W-1:0] DIV_M  = PRE_M | POST_M;
   localparam logic [CFG_W-1:0] LIVE_M = SEL_M | DIV_M;

   if ((SEL_M & DIV_M) != '0 || (PRE_M & POST_M) != '0) begin : g_overlap
      $error("cdiv_cfg_reg: control fields overlap");
   end
   if (SEL_LSB + SEL_W > CFG_W || PRE_LSB + PRE_W > CFG_W ||
       POST_LSB + POST_W > CFG_W) begin : g_range
      $error("cdiv_cfg_reg: field beyond word width");
   end

   logic [CFG_W-1:0] word_d;

   always_comb begin
      word_d = word_q;
      if (wr_all)      word_d = wdata & LIVE_M;
      else if (wr_div) word_d = (word_q & ~DIV_M) | (wdata & DIV_M);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end

   assign sel_o  = word_q[SEL_LSB  +: SEL_W];
   assign pre_o  = word_q[PRE_LSB  +: PRE_W];
   assign post_o = word_q[POST_LSB +: POST_W];

   // R7: a divider-only write never touches the selector
   p_div_keeps_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_div && !wr_all) |=> $stable(word_q[SEL_LSB +: SEL_W]));

   // R7: a divider-only write never touches bits outside the divide fields
   p_div_keeps_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_div && !wr_all) |=> $stable(word_q & ~DIV_M));

   // R8: bits outside the live fields stay zero
   p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_all |=> ((word_q & ~LIVE_M) == '0));

   // R8: no write means the word holds
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_all && !wr_div) |=> $stable(word_q));

endmodule

// File: rtl/cdiv_src_pick.sv
module cdiv_src_pick #(
   parameter int unsigned SRC_N = 4,
   parameter int unsigned SEL_W = 2
) (
   input  logic [SRC_N-1:0] ticks,
   input  logic [SEL_W-1:0] sel,
   output logic             picked
);

   if ((1 << SEL_W) < SRC_N) begin : g_bad_sel
      $error("cdiv_src_pick: selector too narrow for source count");
   end

   if ((1 << SEL_W) == SRC_N) begin : g_full
      assign picked = ticks[sel];
   end else begin : g_sparse
      always_comb begin
         picked = 1'b0;
         for (int unsigned i = 0; i < SRC_N; i++) begin
            if (sel == SEL_W'(i)) picked = ticks[i];
         end
      end
   end

endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage #(
   parameter int unsigned CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_in,
   input  logic          bypass,
   input  logic [CW-1:0] term,
   output logic          fire
);

   if (CW < 1 || CW > 16) begin : g_bad_cw
      $error("cdiv_stage: code width out of range");
   end

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap = (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (tick_in && !bypass)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
   end

   assign fire = tick_in && (bypass || wrap);

   // R9: the count never runs past the terminal value it was loaded with
   p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= term);

   // R5: a bypassed stage keeps its count
   p_bypass_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> $stable(cnt_q));

endmodule

// File: rtl/muxclk_cascade_div.sv
module muxclk_cascade_div
   import cdiv_pkg::*;
#(
   parameter int unsigned SRC_N    = SRC_N_DEF,
   parameter int unsigned SEL_LSB  = SEL_LSB_DEF,
   parameter int unsigned PRE_LSB  = PRE_LSB_DEF,
   parameter int unsigned PRE_W    = PRE_W_DEF,
   parameter int unsigned POST_LSB = POST_LSB_DEF,
   parameter int unsigned POST_W   = POST_W_DEF,
   parameter int unsigned PRE_SRC  = SRC_N_DEF - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] src_tick,
   input  logic             cfg_wr,
   input  logic             div_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   output logic             out_tick
);

   localparam int unsigned SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

   if (SRC_N < 2 || SRC_N > 16) begin : g_bad_n
      $error("muxclk_cascade_div: source count out of range");
   end
   if (PRE_SRC >= SRC_N) begin : g_bad_pre
      $error("muxclk_cascade_div: pre-divided source does not exist");
   end

   typedef struct packed {
      logic [SEL_W-1:0]  sel;
      logic [PRE_W-1:0]  pre;
      logic [POST_W-1:0] post;
   } cfg_t;

   cfg_t reg_cfg, act_cfg;
   logic sel_tick, pre_fire, post_fire, use_pre;

   cdiv_cfg_reg #(
      .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .PRE_LSB(PRE_LSB), .PRE_W(PRE_W),
      .POST_LSB(POST_LSB), .POST_W(POST_W)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_all(cfg_wr), .wr_div(div_wr),
      .wdata(cfg_wdata), .word_q(cfg_rdata),
      .sel_o(reg_cfg.sel), .pre_o(reg_cfg.pre), .post_o(reg_cfg.post)
   );

   // Active settings reload only at an output-period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         act_cfg <= '0;
      else if (post_fire) act_cfg <= reg_cfg;
   end

   cdiv_src_pick #(.SRC_N(SRC_N), .SEL_W(SEL_W)) u_pick (
      .ticks(src_tick), .sel(act_cfg.sel), .picked(sel_tick)
   );

   assign use_pre = (act_cfg.sel == SEL_W'(PRE_SRC));

   cdiv_stage #(.CW(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_in(sel_tick), .bypass(!use_pre),
      .term(act_cfg.pre), .fire(pre_fire)
   );

   cdiv_stage #(.CW(POST_W)) u_post (
      .clk(clk), .rst_n(rst_n), .tick_in(pre_fire), .bypass(1'b0),
      .term(act_cfg.post), .fire(post_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_tick <= 1'b0;
      else        out_tick <= post_fire;
   end

   // R9: active settings hold between period boundaries
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !post_fire |=> $stable(act_cfg));

   // R10: an output tick needs a source tick one cycle earlier
   p_out_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |-> $past(|src_tick));

   // R2: without any tick on the active source, no output tick follows
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !src_tick[act_cfg.sel] |=> !out_tick);

endmodule

// File: tb/muxclk_cascade_div_test.sv
module muxclk_cascade_div_test;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_tick = '0;
   logic        cfg_wr = 1'b0;
   logic        div_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        out_tick;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   // bench model of the active and stored settings
   logic [31:0] model_word = '0;
   logic [3:0]  cur_mask = 4'b0001;
   int          cur_ratio = 1;

   always #(CLK_PERIOD/2) clk = ~clk;

   muxclk_cascade_div uut (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_wr(cfg_wr),
      .div_wr(div_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .out_tick(out_tick)
   );

   task automatic check(input string req, input logic [31:0] got,
                        input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // one tick on the sources in mask; returns the output seen the next cycle
   task automatic pulse(input logic [3:0] mask, output logic got);
      @(negedge clk); src_tick = mask;
      @(negedge clk); got = out_tick; src_tick = '0;
   endtask

   function automatic int ratio_of(input logic [31:0] w);
      int r;
      r = int'(w[5:4]) + 1;
      if (w[17:16] == 2'd3) r = r * (int'(w[12:8]) + 1);
      return r;
   endfunction

   task automatic run(input string req, input int n);
      logic g;
      for (int i = 1; i <= n; i++) begin
         pulse(cur_mask, g);
         check(req, {31'd0, g}, {31'd0, (i % cur_ratio) == 0});
      end
   endtask

   task automatic write(input bit full, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = full; div_wr = !full; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0; div_wr = 1'b0;
      if (full) model_word = d & 32'h0003_1F30;
      else model_word = (model_word & ~32'h0000_1F30) | (d & 32'h0000_1F30);
   endtask

   // write, finish the old period (R9), then adopt the new settings
   task automatic set_cfg(input bit full, input logic [31:0] d);
      write(full, d);
      run("R9 old period", cur_ratio);
      cur_mask  = 4'b0001 << model_word[17:16];
      cur_ratio = ratio_of(model_word);
   endtask

   task automatic t_reset;
      logic g;
      check("R1 reset word", cfg_rdata, 32'h0);
      check("R10 idle out", {31'd0, out_tick}, 32'd0);
      run("R1 src0 pass", 3);
      @(negedge clk);
      check("R10 single cycle", {31'd0, out_tick}, 32'd0);
      pulse(4'b0001, g);
      check("R10 pass again", {31'd0, g}, 32'd1);
   endtask

   task automatic t_select;
      logic g;
      set_cfg(1'b1, 32'h0001_0000);
      pulse(4'b1101, g);
      check("R2 other sources ignored", {31'd0, g}, 32'd0);
      run("R2 src1 selected", 3);
   endtask

   task automatic t_post;
      set_cfg(1'b1, 32'h0002_0030);
      run("R3 post ratio 4", 8);
      set_cfg(1'b1, 32'h0000_0010);
      run("R3 post ratio 2", 6);
   endtask

   task automatic t_pre_ignored;
      set_cfg(1'b1, 32'h0000_0F10);
      run("R5 pre ignored src0", 6);
      set_cfg(1'b1, 32'h0002_1F00);
      run("R5 pre ignored src2", 3);
   endtask

   task automatic t_cascade;
      set_cfg(1'b1, 32'h0003_0400);
      run("R4 pre ratio 5", 10);
      set_cfg(1'b1, 32'h0003_0220);
      run("R6 cascade 3x3", 18);
   endtask

   task automatic t_readback;
      write(1'b1, 32'hFFFF_FFFF);
      check("R8 read mask", cfg_rdata, 32'h0003_1F30);
      run("R9 old period", cur_ratio);
      cur_mask = 4'b1000; cur_ratio = ratio_of(model_word);
      check("R6 max ratio value", cur_ratio, 32'd128);
      run("R6 cascade 32x4", 128);
   endtask

   task automatic t_div_write;
      write(1'b0, 32'hFFFC_E1DF);
      check("R7 div write keeps sel", cfg_rdata, 32'h0003_0110);
      run("R9 old period", cur_ratio);
      cur_ratio = ratio_of(model_word);
      run("R7 new div on src3", 8);
      @(negedge clk);
      cfg_wr = 1'b1; div_wr = 1'b1; cfg_wdata = 32'h0000_0000;
      @(negedge clk);
      cfg_wr = 1'b0; div_wr = 1'b0;
      model_word = 32'h0;
      check("R7 full write wins", cfg_rdata, 32'h0);
      run("R9 old period", cur_ratio);
      cur_mask = 4'b0001; cur_ratio = 1;
      run("R7 back to src0", 2);
   endtask

   task automatic t_mid_period;
      logic g;
      set_cfg(1'b1, 32'h0000_0030);
      run("R9 ratio 4 start", 2);
      write(1'b1, 32'h0001_0000);
      pulse(4'b0010, g);
      check("R9 new src waits", {31'd0, g}, 32'd0);
      pulse(4'b0001, g);
      check("R9 old count 3", {31'd0, g}, 32'd0);
      pulse(4'b0001, g);
      check("R9 old period ends", {31'd0, g}, 32'd1);
      pulse(4'b0001, g);
      check("R9 old src dropped", {31'd0, g}, 32'd0);
      cur_mask = 4'b0010; cur_ratio = 1;
      run("R9 new src live", 2);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select();
      t_post();
      t_pre_ignored();
      t_cascade();
      t_readback();
      t_div_write();
      t_mid_period();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule